// File: doc/BRIEF.md
# Deferred-Fault Register File

This block is a register file whose entries each carry one extra flag that marks the stored value as invalid, because a speculatively hoisted instruction that wrote it hit a terminating fault. The fault is not reported when the speculative instruction runs. It is reported later, when a non-speculative instruction uses the marked value. A speculative instruction that reads a marked value passes the mark on to its own destination. Resumable faults are reported at once, whether or not the instruction is speculative.

Instructions are handled one per clock edge. When `issueValid` is high, the source operands are read combinationally from the current state, and any write lands on that same edge. The fault outputs are registered, so each is a one-cycle pulse in the cycle after issue. Stores have no place to hold a mark, so a store flagged speculative is refused with an error pulse.

Top module: `poison_regfile`

## Requirements
- R1: After reset every register reads zero with its flag clear, and `excReq`, `resumeReq` and `storeErr` are low.
- R2: An issued instruction that is not a store, has `wrEn` high, no fault, and either is non-speculative or reads no flagged operand writes `wrData` to `wrAddr`. The value can be read from the next cycle on.
- R3: A speculative non-store instruction with `excValid` high and `excTerminating` high sets the flag of its destination. It leaves the data unchanged and raises no `excReq`.
- R4: A non-speculative instruction that uses a flagged operand (a read port counts only when its `rdUse` bit is high) pulses `excReq` with `excDeferred`=1 in the next cycle. `excReg` gives that operand's index, and port A wins when both ports are flagged. Nothing is written.
- R5: A speculative non-store instruction that uses a flagged operand sets its destination's flag and raises no `excReq`.
- R6: A non-store instruction with `excValid` high and `excTerminating` low pulses `resumeReq` in the next cycle, with `excReg` set to the destination index. This holds whether or not the instruction is speculative, and nothing is written.
- R7: A non-speculative instruction with a terminating fault and no flagged operand pulses `excReq` with `excDeferred`=0 and `excReg` set to the destination. Nothing is written.
- R8: Stores never write the register file. A speculative store pulses `storeErr` in the next cycle and does nothing else. A non-speculative store that uses a flagged operand raises a deferred fault as in R4.
- R9: A successful write clears the destination's flag.
- R10: Register 0 always reads zero, its flag always reads clear, and writes and flag updates to it have no effect.
- R11: Each output pulse lasts one cycle. A pulse is low in any cycle that does not follow an issue that produced it.
- R12: A flagged register on a read port whose `rdUse` bit is low does not affect the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An instruction is issued this cycle |
| issueSpec | input | 1 | The instruction was hoisted speculatively |
| issueStore | input | 1 | The instruction is a store (no register write) |
| rdUseA | input | 1 | The instruction uses read port A |
| rdAddrA | input | 5 | Read port A index |
| rdUseB | input | 1 | The instruction uses read port B |
| rdAddrB | input | 5 | Read port B index |
| wrEn | input | 1 | The instruction has a destination register |
| wrAddr | input | 5 | Destination index |
| wrData | input | 32 | Result value |
| excValid | input | 1 | The instruction raised a fault |
| excTerminating | input | 1 | 1 = terminating fault, 0 = resumable fault |
| rdDataA | output | 32 | Port A data |
| rdDataB | output | 32 | Port B data |
| rdPoisA | output | 1 | Port A register is flagged |
| rdPoisB | output | 1 | Port B register is flagged |
| excReq | output | 1 | Terminating fault request pulse |
| excDeferred | output | 1 | The fault came from a flagged operand |
| excReg | output | 5 | Register index tied to the last fault |
| resumeReq | output | 1 | Resumable fault request pulse |
| storeErr | output | 1 | Speculative store refused pulse |

## Verification
The assertions assume that the instruction inputs are stable around the clock edge. They also assume that `issueValid` is low during reset, so the first pulse can only follow a real issue. The stimulus changes all inputs at the falling edge. It holds `issueValid` high for exactly one rising edge per instruction and lowers it before the pulses are checked. Read ports are exercised only while no instruction is in flight, so every combinational read reflects settled state.

// File: rtl/pregf_pkg.sv
package pregf_pkg;
  localparam int REG_COUNT = 32;
  localparam int DATA_W    = 32;

  typedef enum logic [1:0] {
    FSEL_SRCA = 2'd0,
    FSEL_SRCB = 2'd1,
    FSEL_DEST = 2'd2
  } faultSel_e;

  typedef struct packed {
    logic      writeData;
    logic      setPoison;
    logic      raiseExc;
    logic      deferred;
    logic      raiseResume;
    logic      rejectStore;
    faultSel_e faultSel;
  } strobe_t;
endpackage

// File: rtl/pregf_dpath.sv
module pregf_dpath
  import pregf_pkg::*;
#(
  parameter int REG_COUNT = pregf_pkg::REG_COUNT,
  parameter int DATA_W    = pregf_pkg::DATA_W,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdPoisA,
  output logic              rdPoisB
);
  logic [DATA_W-1:0]    regQ [REG_COUNT];
  logic [REG_COUNT-1:0] poisonQ;

  // Entry 0 is a hard zero and can never be flagged.
  assign regQ[0]    = '0;
  assign poisonQ[0] = 1'b0;

  for (genvar g = 1; g < REG_COUNT; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              p;
    logic              hit;
    assign hit = (wrAddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
        p <= 1'b0;
      end else if (hit) begin
        if (stb.writeData) begin
          q <= wrData;
          p <= 1'b0;
        end else if (stb.setPoison) begin
          p <= 1'b1;
        end
      end
    end
    assign regQ[g]    = q;
    assign poisonQ[g] = p;
  end

  assign rdDataA = regQ[rdAddrA];
  assign rdDataB = regQ[rdAddrB];
  assign rdPoisA = poisonQ[rdAddrA];
  assign rdPoisB = poisonQ[rdAddrB];

  AST_ZERO_REG_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0 && !rdPoisA)); // R10
  AST_POISON_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setPoison && !stb.writeData && wrAddr != '0) |=> poisonQ[$past(wrAddr)]); // R3
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeData && wrAddr != '0) |=>
      (!poisonQ[$past(wrAddr)] && regQ[$past(wrAddr)] == $past(wrData))); // R9
endmodule

// File: rtl/pregf_ctrl.sv
module pregf_ctrl
  import pregf_pkg::*;
#(
  parameter int REG_COUNT = pregf_pkg::REG_COUNT,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueSpec,
  input  logic              issueStore,
  input  logic              rdUseA,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic              rdUseB,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              excValid,
  input  logic              excTerminating,
  input  logic              poisA,
  input  logic              poisB,
  output strobe_t           stb,
  output logic              excReq,
  output logic              excDeferred,
  output logic [ADDR_W-1:0] excReg,
  output logic              resumeReq,
  output logic              storeErr
);
  logic srcPoisA, srcPoisB, srcPois;
  assign srcPoisA = rdUseA && poisA;
  assign srcPoisB = rdUseB && poisB;
  assign srcPois  = srcPoisA || srcPoisB;

  always_comb begin
    stb = '0;
    stb.faultSel = FSEL_DEST;
    if (issueValid) begin
      if (issueStore) begin
        if (issueSpec) begin
          stb.rejectStore = 1'b1;
        end else if (srcPois) begin
          stb.raiseExc = 1'b1;
          stb.deferred = 1'b1;
          stb.faultSel = srcPoisA ? FSEL_SRCA : FSEL_SRCB;
        end
      end else if (!issueSpec && srcPois) begin
        stb.raiseExc = 1'b1;
        stb.deferred = 1'b1;
        stb.faultSel = srcPoisA ? FSEL_SRCA : FSEL_SRCB;
      end else if (excValid && !excTerminating) begin
        stb.raiseResume = 1'b1;
      end else if (excValid && !issueSpec) begin
        stb.raiseExc = 1'b1;
      end else if (issueSpec && (excValid || srcPois)) begin
        stb.setPoison = wrEn;
      end else begin
        stb.writeData = wrEn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excReq      <= 1'b0;
      excDeferred <= 1'b0;
      excReg      <= '0;
      resumeReq   <= 1'b0;
      storeErr    <= 1'b0;
    end else begin
      excReq      <= stb.raiseExc;
      excDeferred <= stb.deferred;
      resumeReq   <= stb.raiseResume;
      storeErr    <= stb.rejectStore;
      if (stb.raiseExc || stb.raiseResume) begin
        case (stb.faultSel)
          FSEL_SRCA: excReg <= rdAddrA;
          FSEL_SRCB: excReg <= rdAddrB;
          default:   excReg <= wrAddr;
        endcase
      end
    end
  end

  AST_SPEC_NO_EXC: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueSpec) |=> !excReq); // R5
  AST_SPEC_STORE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueSpec && issueStore) |=> (storeErr && !excReq && !resumeReq)); // R8
  AST_PULSE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (excReq || resumeReq || storeErr) |-> $past(issueValid)); // R11
  AST_ONE_FAULT_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({excReq, resumeReq, storeErr})); // R6
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
  import pregf_pkg::*;
#(
  parameter int REG_COUNT = pregf_pkg::REG_COUNT,
  parameter int DATA_W    = pregf_pkg::DATA_W,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueSpec,
  input  logic              issueStore,
  input  logic              rdUseA,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic              rdUseB,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              excValid,
  input  logic              excTerminating,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdPoisA,
  output logic              rdPoisB,
  output logic              excReq,
  output logic              excDeferred,
  output logic [ADDR_W-1:0] excReg,
  output logic              resumeReq,
  output logic              storeErr
);
  strobe_t stb;

  pregf_ctrl #(.REG_COUNT(REG_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueSpec(issueSpec), .issueStore(issueStore),
    .rdUseA(rdUseA), .rdAddrA(rdAddrA), .rdUseB(rdUseB), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr),
    .excValid(excValid), .excTerminating(excTerminating),
    .poisA(rdPoisA), .poisB(rdPoisB),
    .stb(stb),
    .excReq(excReq), .excDeferred(excDeferred), .excReg(excReg),
    .resumeReq(resumeReq), .storeErr(storeErr)
  );

  pregf_dpath #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .rdPoisA(rdPoisA), .rdPoisB(rdPoisB)
  );
endmodule

// File: tb/poison_regfile_tb.sv
module poison_regfile_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 0, issueSpec = 0, issueStore = 0;
  logic        rdUseA = 0, rdUseB = 0, wrEn = 0, excValid = 0, excTerminating = 0;
  logic [4:0]  rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdDataA, rdDataB;
  logic        rdPoisA, rdPoisB, excReq, excDeferred, resumeReq, storeErr;
  logic [4:0]  excReg;
  int          nChecks = 0;
  int          nFails = 0;

  always #10 clk = ~clk;

  poison_regfile u_dut (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // Drive one instruction for a single rising edge; returns at the following falling edge.
  task automatic issue(input logic spec, input logic store,
                       input logic useA, input logic [4:0] a,
                       input logic useB, input logic [4:0] b,
                       input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic ev, input logic et);
    @(negedge clk);
    issueValid = 1; issueSpec = spec; issueStore = store;
    rdUseA = useA; rdAddrA = a; rdUseB = useB; rdAddrB = b;
    wrEn = we; wrAddr = wa; wrData = wd; excValid = ev; excTerminating = et;
    @(posedge clk);
    @(negedge clk);
    issueValid = 0; issueSpec = 0; issueStore = 0; rdUseA = 0; rdUseB = 0;
    wrEn = 0; excValid = 0; excTerminating = 0;
  endtask

  task automatic readA(input logic [4:0] a, input string req, input logic [31:0] expData, input logic expPois);
    rdAddrA = a;
    #1;
    check(req, $sformatf("data r%0d", a), rdDataA, expData);
    check(req, $sformatf("flag r%0d", a), {31'b0, rdPoisA}, {31'b0, expPois});
  endtask

  task automatic pulses(input string req, input logic e, input logic d, input logic r, input logic s);
    check(req, "excReq", {31'b0, excReq}, {31'b0, e});
    if (e) check(req, "excDeferred", {31'b0, excDeferred}, {31'b0, d});
    check(req, "resumeReq", {31'b0, resumeReq}, {31'b0, r});
    check(req, "storeErr", {31'b0, storeErr}, {31'b0, s});
  endtask

  task automatic tResetState();
    readA(5'd0, "R1", 32'h0, 1'b0);
    readA(5'd7, "R1", 32'h0, 1'b0);
    readA(5'd31, "R1", 32'h0, 1'b0);
    pulses("R1", 0, 0, 0, 0);
  endtask

  task automatic tPlainWrite();
    issue(0, 0, 0, 0, 0, 0, 1, 5'd5, 32'hA5A5_0001, 0, 0);
    pulses("R2", 0, 0, 0, 0);
    readA(5'd5, "R2", 32'hA5A5_0001, 1'b0);
    issue(0, 0, 0, 0, 0, 0, 1, 5'd7, 32'h0000_0077, 0, 0);
    readA(5'd7, "R2", 32'h77, 1'b0);
    issue(0, 0, 0, 0, 0, 0, 1, 5'd0, 32'hDEAD_BEEF, 0, 0);
    readA(5'd0, "R10", 32'h0, 1'b0);
  endtask

  task automatic tSpecTerminate();
    issue(1, 0, 0, 0, 0, 0, 1, 5'd7, 32'h1234_5678, 1, 1);
    pulses("R3", 0, 0, 0, 0);
    readA(5'd7, "R3", 32'h77, 1'b1);
    issue(1, 0, 0, 0, 0, 0, 1, 5'd0, 32'h1, 1, 1);
    readA(5'd0, "R10", 32'h0, 1'b0);
  endtask

  task automatic tSpecPropagate();
    issue(1, 0, 1, 5'd7, 0, 0, 1, 5'd9, 32'h9999, 0, 0);
    pulses("R5", 0, 0, 0, 0);
    readA(5'd9, "R5", 32'h0, 1'b1);
  endtask

  task automatic tDeferredFault();
    issue(0, 0, 1, 5'd5, 1, 5'd9, 1, 5'd11, 32'h11, 0, 0);
    pulses("R4", 1, 1, 0, 0);
    check("R4", "excReg port B", {27'b0, excReg}, 32'd9);
    readA(5'd11, "R4", 32'h0, 1'b0);
    issue(0, 0, 1, 5'd7, 1, 5'd9, 1, 5'd11, 32'h11, 0, 0);
    pulses("R4", 1, 1, 0, 0);
    check("R4", "excReg port A wins", {27'b0, excReg}, 32'd7);
    @(negedge clk);
    pulses("R11", 0, 0, 0, 0);
  endtask

  task automatic tUnusedPort();
    issue(0, 0, 0, 5'd7, 1, 5'd5, 1, 5'd10, 32'h0000_0010, 0, 0);
    pulses("R12", 0, 0, 0, 0);
    readA(5'd10, "R12", 32'h10, 1'b0);
  endtask

  task automatic tClearOnWrite();
    issue(0, 0, 0, 0, 0, 0, 1, 5'd7, 32'h0000_0707, 0, 0);
    readA(5'd7, "R9", 32'h707, 1'b0);
  endtask

  task automatic tResumable();
    issue(1, 0, 0, 0, 0, 0, 1, 5'd12, 32'h12, 1, 0);
    pulses("R6", 0, 0, 1, 0);
    check("R6", "excReg", {27'b0, excReg}, 32'd12);
    readA(5'd12, "R6", 32'h0, 1'b0);
    issue(0, 0, 0, 0, 0, 0, 1, 5'd15, 32'h15, 1, 0);
    pulses("R6", 0, 0, 1, 0);
    check("R6", "excReg", {27'b0, excReg}, 32'd15);
    @(negedge clk);
    pulses("R11", 0, 0, 0, 0);
  endtask

  task automatic tPlainTerminate();
    issue(0, 0, 1, 5'd5, 0, 0, 1, 5'd13, 32'h13, 1, 1);
    pulses("R7", 1, 0, 0, 0);
    check("R7", "excReg", {27'b0, excReg}, 32'd13);
    readA(5'd13, "R7", 32'h0, 1'b0);
  endtask

  task automatic tStores();
    issue(1, 1, 1, 5'd5, 0, 0, 1, 5'd14, 32'h14, 0, 0);
    pulses("R8", 0, 0, 0, 1);
    readA(5'd14, "R8", 32'h0, 1'b0);
    issue(0, 1, 1, 5'd5, 1, 5'd9, 1, 5'd14, 32'h14, 0, 0);
    pulses("R8", 1, 1, 0, 0);
    check("R8", "excReg", {27'b0, excReg}, 32'd9);
    readA(5'd14, "R8", 32'h0, 1'b0);
    issue(0, 1, 1, 5'd5, 0, 0, 1, 5'd14, 32'h14, 0, 0);
    pulses("R8", 0, 0, 0, 0);
    readA(5'd14, "R8", 32'h0, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tPlainWrite();
    tSpecTerminate();
    tSpecPropagate();
    tDeferredFault();
    tUnusedPort();
    tClearOnWrite();
    tResumable();
    tPlainTerminate();
    tStores();
    finishRun();
  end
endmodule